// File: doc/BRIEF.md
# Digital Type II Angle Tracking Loop

This block follows the angle of a rotating shaft from sampled sine and cosine pickoff values and holds it as a 14-bit natural binary word. In that word the most significant bit is worth 180 degrees and one count is 360/16384 degrees, about 1.3 arc minutes. The block runs all the time and needs no start command. The front end supplies a signed sine sample and a signed cosine sample. Both still ride on the excitation carrier. With them comes a bit that gives the present carrier polarity. A one-cycle valid strobe marks each new sample pair.

For each accepted sample the block looks up the sine and cosine of its own angle word in a quarter-wave table folded by the two top angle bits. It forms the tracking error as the sine sample times cos(phi) minus the cosine sample times sin(phi), which is proportional to sin(theta - phi). The error is rectified against the carrier polarity and summed over one carrier half-cycle. Each completed half-cycle sum goes to a saturating velocity integrator and to a proportional lead path. Their clipped sum is the per-clock increment of a phase accumulator. Every carry or borrow of that accumulator moves the angle counter by exactly one count. The loop therefore holds two integrators and tracks a constant rate with no steady lag.

A four-state sequencer runs each sample. ST_WAIT accepts a sample when `sample_valid` is high, latches it with the table outputs and moves to ST_MULT. ST_MULT registers the scaled cross-product error and moves to ST_DEMOD. ST_DEMOD updates the error magnitude. If the carrier polarity of the sample differs from the last one seen, ST_DEMOD closes the half-cycle sum, opens a new one and moves to ST_UPDATE. Otherwise it adds to the running sum and returns to ST_WAIT. ST_UPDATE loads the new velocity and increment and returns to ST_WAIT. Samples must be at least four clocks apart.

Top module: `angle_tracker`

## Requirements
- R1: A synchronous reset clears the angle, velocity, error magnitude, increment and both demodulator sums; all three outputs read 0 on the cycle after a clock edge that saw `rst` high.
- R2: Between consecutive clocks the angle word changes by 0, +1 or -1 modulo 2^14, and never by more.
- R3: The counter steps up only while the loop increment is positive and down only while it is negative, so during a ramp the net count of steps equals the angle travelled.
- R4: For a stationary shaft in any quadrant, with amplitude about 1500 and polarity changing every 8 samples, the angle settles to within 24 counts of the shaft angle.
- R5: For a shaft turning at a constant rate, the settled angle stays within 24 counts of the shaft angle, and `velocity` reads the rate in counts per clock times 2^16, within 25%.
- R6: Angle wrap is a single step in both directions: 16383 goes to 0 on an up step and 0 goes to 16383 on a down step.
- R7: Velocity and increment are clipped to plus or minus `vel_limit` rather than wrapping. A large step drives `velocity` to exactly `vel_limit`, and the loop then still locks.
- R8: The loop filter updates only when the polarity bit of an accepted sample differs from that of the previous closing sample. With `ref_pol` held at 0 from reset, `velocity` stays 0 and the angle stays 0 whatever the samples are.
- R9: `err_mag` equals |(sin_in*cos(phi) - cos_in*sin(phi)) >>> 11|, using an arithmetic shift and table amplitude 2047 (at phi = 0 the table gives sin 0 and cos 2047). It becomes valid after the second clock edge that follows the edge accepting the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | One-cycle strobe marking a new sample pair |
| sin_in | input | 12 | Signed sample proportional to carrier times sin(theta) |
| cos_in | input | 12 | Signed sample proportional to carrier times cos(theta) |
| ref_pol | input | 1 | Carrier polarity at sampling time, 1 = positive half |
| vel_limit | input | 16 | Largest allowed increment magnitude, in 2^-16 counts per clock |
| angle | output | 14 | Tracked angle, natural binary |
| velocity | output | 17 | Signed velocity integrator, 2^-16 counts per clock |
| err_mag | output | 13 | Magnitude of the latest scaled cross-product error |

## Verification
First the shaft is held still at ten angles about 37 degrees apart, which covers every quadrant fold of the table and every sign combination of the error terms. Next come rising and falling ramps at one count per sample. These separate true Type II tracking, with zero lag and a correct velocity reading, from a proportional-only loop, and they also take the counter through its wrap in both directions. With the polarity bit held constant, the tests expose any update that happens outside a half-cycle boundary, and they give exact error magnitudes for positive and negative products. A large step under a lowered `vel_limit` shows saturation as opposed to wrap of the velocity integrator.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_MULT,
        ST_DEMOD,
        ST_UPDATE
    } trk_state_t;

    // Rational sine approximation over [0, pi/2]: idx in 0..quarter maps to
    // angle idx*pi/(2*quarter); value is 4p/(5q^2 - p) scaled by amp.
    function automatic int quarter_sine(input int idx, input int quarter, input int amp);
        longint p;
        longint den;
        longint num;
        p   = longint'(idx) * longint'(2 * quarter - idx);
        den = 5 * longint'(quarter) * longint'(quarter) - p;
        num = 4 * p * longint'(amp);
        return int'((2 * num + den) / (2 * den));
    endfunction

endpackage

// File: rtl/phase_trig.sv
module phase_trig
    import tracker_pkg::*;
#(
    parameter int LUT_ADDR_W = 10,
    parameter int TRIG_W     = 12
) (
    input  logic [LUT_ADDR_W+1:0]     phase_hi,
    output logic signed [TRIG_W-1:0]  sin_phi,
    output logic signed [TRIG_W-1:0]  cos_phi
);
    localparam int QN  = 1 << LUT_ADDR_W;
    localparam int AMP = (1 << (TRIG_W - 1)) - 1;
    localparam int IW  = LUT_ADDR_W + 1;

    logic [TRIG_W-1:0] rom [0:QN];

    for (genvar i = 0; i <= QN; i++) begin : g_rom
        localparam int VAL = quarter_sine(i, QN, AMP);
        assign rom[i] = TRIG_W'(VAL);
    end

    logic [1:0]        quad;
    logic [IW-1:0]     idx_fwd;
    logic [IW-1:0]     idx_rev;
    logic [TRIG_W-1:0] mag_s;
    logic [TRIG_W-1:0] mag_c;

    always_comb begin
        quad    = phase_hi[LUT_ADDR_W+1:LUT_ADDR_W];
        idx_fwd = {1'b0, phase_hi[LUT_ADDR_W-1:0]};
        idx_rev = IW'(QN) - idx_fwd;
        mag_s   = quad[0] ? rom[idx_rev] : rom[idx_fwd];
        mag_c   = quad[0] ? rom[idx_fwd] : rom[idx_rev];
        sin_phi = quad[1] ? -$signed(mag_s) : $signed(mag_s);
        cos_phi = (quad[1] ^ quad[0]) ? -$signed(mag_c) : $signed(mag_c);
    end

endmodule

// File: rtl/step_nco.sv
module step_nco #(
    parameter int ANGLE_W = 14,
    parameter int NCO_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [NCO_W:0]   inc,
    output logic [ANGLE_W-1:0]      angle
);
    localparam int SW = NCO_W + 2;

    logic [NCO_W-1:0]     ph;
    logic signed [SW-1:0] sum;
    logic                 carry_up;
    logic                 borrow_dn;

    always_comb begin
        sum       = $signed({2'b00, ph}) + $signed({inc[NCO_W], inc});
        borrow_dn = sum[SW-1];
        carry_up  = !sum[SW-1] && sum[NCO_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= '0;
            angle <= '0;
        end else begin
            ph <= sum[NCO_W-1:0];
            if (carry_up)
                angle <= angle + 1'b1;
            else if (borrow_dn)
                angle <= angle - 1'b1;
        end
    end

endmodule

// File: rtl/angle_tracker.sv
module angle_tracker
    import tracker_pkg::*;
#(
    parameter int ANGLE_W    = 14,
    parameter int SAMPLE_W   = 12,
    parameter int TRIG_W     = 12,
    parameter int LUT_ADDR_W = 10,
    parameter int NCO_W      = 16,
    parameter int ACC_W      = 24,
    parameter int KP_SH      = 7,
    parameter int KI_SH      = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample_valid,
    input  logic signed [SAMPLE_W-1:0] sin_in,
    input  logic signed [SAMPLE_W-1:0] cos_in,
    input  logic                      ref_pol,
    input  logic [NCO_W-1:0]          vel_limit,
    output logic [ANGLE_W-1:0]        angle,
    output logic signed [NCO_W:0]     velocity,
    output logic [SAMPLE_W:0]         err_mag
);
    localparam int PW  = SAMPLE_W + TRIG_W;
    localparam int EW  = SAMPLE_W + 1;
    localparam int VW  = NCO_W + 1;
    localparam int BIG = (ACC_W + KP_SH > VW) ? ACC_W + KP_SH : VW;
    localparam int LW  = BIG + 2;

    trk_state_t st, st_nx;

    logic signed [SAMPLE_W-1:0] smp_s, smp_c;
    logic                       smp_pol, last_pol;
    logic signed [TRIG_W-1:0]   sin_phi, cos_phi, phi_s, phi_c;
    logic signed [EW-1:0]       err_q, err_nx;
    logic [EW-1:0]              mag_nx;
    logic signed [ACC_W-1:0]    acc_run, acc_done, demod;
    logic signed [VW-1:0]       inc_q, vel_nx, inc_nx;
    logic signed [PW-1:0]       prod_a, prod_b;
    logic signed [PW:0]         diff;
    logic signed [LW-1:0]       acc_x, lim_x, vsum, vclip, isum, iclip;
    logic                       pol_edge;

    phase_trig #(.LUT_ADDR_W(LUT_ADDR_W), .TRIG_W(TRIG_W)) u_trig (
        .phase_hi (angle[ANGLE_W-1 -: LUT_ADDR_W+2]),
        .sin_phi  (sin_phi),
        .cos_phi  (cos_phi)
    );

    step_nco #(.ANGLE_W(ANGLE_W), .NCO_W(NCO_W)) u_nco (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc_q),
        .angle (angle)
    );

    function automatic logic signed [LW-1:0] clip(input logic signed [LW-1:0] x,
                                                  input logic signed [LW-1:0] m);
        if (x > m)  return m;
        if (x < -m) return -m;
        return x;
    endfunction

    // error, demodulation and loop filter arithmetic
    always_comb begin
        prod_a   = PW'(smp_s) * PW'(phi_c);
        prod_b   = PW'(smp_c) * PW'(phi_s);
        diff     = $signed({prod_a[PW-1], prod_a}) - $signed({prod_b[PW-1], prod_b});
        err_nx   = EW'(diff >>> (TRIG_W - 1));
        mag_nx   = err_q[EW-1] ? EW'(-err_q) : EW'(err_q);
        demod    = smp_pol ? ACC_W'(err_q) : -ACC_W'(err_q);
        pol_edge = (smp_pol != last_pol);
        acc_x    = LW'(acc_done);
        lim_x    = $signed(LW'(vel_limit));
        vsum     = LW'(velocity) + (acc_x <<< KI_SH);
        vclip    = clip(vsum, lim_x);
        isum     = vclip + (acc_x <<< KP_SH);
        iclip    = clip(isum, lim_x);
        vel_nx   = VW'(vclip);
        inc_nx   = VW'(iclip);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_WAIT;
        else     st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_WAIT:   if (sample_valid) st_nx = ST_MULT;
            ST_MULT:   st_nx = ST_DEMOD;
            ST_DEMOD:  st_nx = pol_edge ? ST_UPDATE : ST_WAIT;
            ST_UPDATE: st_nx = ST_WAIT;
            default:   st_nx = ST_WAIT;
        endcase
    end

    // per-state datapath outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_s    <= '0;
            smp_c    <= '0;
            smp_pol  <= 1'b0;
            last_pol <= 1'b0;
            phi_s    <= '0;
            phi_c    <= '0;
            err_q    <= '0;
            err_mag  <= '0;
            acc_run  <= '0;
            acc_done <= '0;
            velocity <= '0;
            inc_q    <= '0;
        end else begin
            unique case (st)
                ST_WAIT: if (sample_valid) begin
                    smp_s   <= sin_in;
                    smp_c   <= cos_in;
                    smp_pol <= ref_pol;
                    phi_s   <= sin_phi;
                    phi_c   <= cos_phi;
                end
                ST_MULT: err_q <= err_nx;
                ST_DEMOD: begin
                    err_mag <= mag_nx;
                    if (pol_edge) begin
                        acc_done <= acc_run;
                        acc_run  <= demod;
                        last_pol <= smp_pol;
                    end else begin
                        acc_run <= acc_run + demod;
                    end
                end
                ST_UPDATE: begin
                    velocity <= vel_nx;
                    inc_q    <= inc_nx;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/angle_tracker_chk.sv
module angle_tracker_chk #(
    parameter int ANGLE_W  = 14,
    parameter int NCO_W    = 16,
    parameter int MAG_W    = 13
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ANGLE_W-1:0]     angle,
    input logic signed [NCO_W:0]  velocity,
    input logic [MAG_W-1:0]       err_mag,
    input logic [NCO_W-1:0]       vel_limit,
    input logic signed [NCO_W:0]  inc,
    input logic                   in_demod,
    input logic                   in_update
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (angle == '0 && velocity == '0 && err_mag == '0));

    p_single_step_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (angle == $past(angle)) || (angle == $past(angle) + 1'b1) || (angle == $past(angle) - 1'b1));

    p_up_needs_pos_r3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (angle == $past(angle) + 1'b1) |-> ($past(inc) > 0));

    p_dn_needs_neg_r3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (angle == $past(angle) - 1'b1) |-> ($past(inc) < 0));

    p_vel_clipped_r7: assert property (@(posedge clk) disable iff (rst || !past_ok)
        in_update |=> (velocity <= $signed({1'b0, $past(vel_limit)}) &&
                       velocity >= -$signed({1'b0, $past(vel_limit)})));

    p_vel_only_on_edge_r8: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$stable(velocity) |-> $past(in_update));

    p_mag_after_demod_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$stable(err_mag) |-> $past(in_demod));

endmodule

bind angle_tracker angle_tracker_chk #(
    .ANGLE_W (ANGLE_W),
    .NCO_W   (NCO_W),
    .MAG_W   (SAMPLE_W + 1)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .angle     (angle),
    .velocity  (velocity),
    .err_mag   (err_mag),
    .vel_limit (vel_limit),
    .inc       (inc_q),
    .in_demod  (st == ST_DEMOD),
    .in_update (st == ST_UPDATE)
);

// File: tb/angle_tracker_tb.sv
module angle_tracker_tb;
    localparam int    FULL = 16384;
    localparam real   AMPL = 1500.0;
    localparam real   TWO_PI = 6.283185307179586;
    localparam int    TOL = 24;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_valid = 1'b0;
    logic signed [11:0] sin_in = '0;
    logic signed [11:0] cos_in = '0;
    logic               ref_pol = 1'b0;
    logic [15:0]        vel_limit = 16'd60000;
    logic [13:0]        angle;
    logic signed [16:0] velocity;
    logic [12:0]        err_mag;

    int  total = 0;
    int  bad = 0;
    int  gk = 0;
    real th = 0.0;

    int  multi_jumps = 0, over_lim = 0, ups = 0, downs = 0;
    bit  wrap_up = 0, wrap_dn = 0, hit_lim = 0, prev_ok = 0;
    logic [13:0] prev_ang;

    always #4 clk = ~clk;

    angle_tracker u_dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .sin_in(sin_in), .cos_in(cos_in), .ref_pol(ref_pol),
        .vel_limit(vel_limit), .angle(angle), .velocity(velocity), .err_mag(err_mag)
    );

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst) prev_ok = 0;
        else begin
            if (prev_ok) begin
                int d;
                d = (int'(angle) - int'(prev_ang) + FULL) % FULL;
                if (d == 1) ups++;
                else if (d == FULL - 1) downs++;
                else if (d != 0) multi_jumps++;
                if (prev_ang == 14'd16383 && angle == 14'd0) wrap_up = 1;
                if (prev_ang == 14'd0 && angle == 14'd16383) wrap_dn = 1;
            end
            if (velocity > $signed({1'b0, vel_limit}) || velocity < -$signed({1'b0, vel_limit}))
                over_lim++;
            if (velocity == $signed({1'b0, vel_limit})) hit_lim = 1;
            prev_ang = angle;
            prev_ok = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wdiff(input int a, input int b);
        int d;
        d = ((a - b) % FULL + FULL) % FULL;
        if (d >= FULL / 2) d -= FULL;
        return d;
    endfunction

    function automatic int th_mod();
        real r;
        r = th - FULL * $floor(th / FULL);
        return int'(r) % FULL;
    endfunction

    task automatic send(input int s, input int c, input logic pol);
        @(posedge clk); #1;
        sin_in = 12'(s);
        cos_in = 12'(c);
        ref_pol = pol;
        sample_valid = 1'b1;
        @(posedge clk); #1;
        sample_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    // n carrier-modulated samples; shaft moves by rate counts per sample
    task automatic track(input int n, input real rate);
        for (int k = 0; k < n; k++) begin
            logic pol;
            int s, c;
            pol = ((gk / 8) % 2) == 1;
            s = int'(AMPL * $sin(TWO_PI * th / FULL));
            c = int'(AMPL * $cos(TWO_PI * th / FULL));
            if (!pol) begin s = -s; c = -c; end
            send(s, c, pol);
            gk++;
            th = th + rate;
        end
    endtask

    task automatic pulse_reset();
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(angle == 0, "R1 reset angle", int'(angle), 0);
        chk(velocity == 0, "R1 reset velocity", int'(velocity), 0);
        chk(err_mag == 0, "R1 reset err_mag", int'(err_mag), 0);

        // exact error magnitude at phi = 0, polarity held low
        send(1000, 300, 1'b0);
        @(negedge clk);
        chk(int'(err_mag) == ((1000 * 2047) >>> 11), "R9 positive product", int'(err_mag), (1000 * 2047) >>> 11);
        send(-1000, -700, 1'b0);
        @(negedge clk);
        chk(int'(err_mag) == -((-1000 * 2047) >>> 11), "R9 negative product", int'(err_mag), -((-1000 * 2047) >>> 11));

        // constant polarity: loop must not move
        for (int k = 0; k < 24; k++) send(-1400, 500, 1'b0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(velocity == 0, "R8 velocity frozen", int'(velocity), 0);
        chk(angle == 0, "R8 angle frozen", int'(angle), 0);

        pulse_reset();
        gk = 0;

        // stationary sweep through all quadrants
        for (int i = 0; i < 10; i++) begin
            th = real'(i * 1700 + 300);
            track(1500, 0.0);
            @(negedge clk);
            chk(wdiff(int'(angle), th_mod()) <= TOL && wdiff(int'(angle), th_mod()) >= -TOL,
                "R4 static lock", int'(angle), th_mod());
        end

        // rising ramp, crossing 16383 -> 0
        track(2000, 1.0);
        ups = 0; downs = 0;
        track(1000, 1.0);
        @(negedge clk);
        chk(wdiff(int'(angle), th_mod()) <= TOL && wdiff(int'(angle), th_mod()) >= -TOL,
            "R5 rising lag", int'(angle), th_mod());
        chk(velocity >= 12288 && velocity <= 20480, "R5 rising velocity", int'(velocity), 16384);
        chk((ups - downs) >= 1000 - 2 * TOL && (ups - downs) <= 1000 + 2 * TOL,
            "R3 net up steps", ups - downs, 1000);
        chk(wrap_up, "R6 wrap up", int'(wrap_up), 1);

        // falling ramp, crossing 0 -> 16383
        track(2000, -1.0);
        ups = 0; downs = 0;
        track(1000, -1.0);
        @(negedge clk);
        chk(wdiff(int'(angle), th_mod()) <= TOL && wdiff(int'(angle), th_mod()) >= -TOL,
            "R5 falling lag", int'(angle), th_mod());
        chk(velocity <= -12288 && velocity >= -20480, "R5 falling velocity", int'(velocity), -16384);
        chk((downs - ups) >= 1000 - 2 * TOL && (downs - ups) <= 1000 + 2 * TOL,
            "R3 net down steps", downs - ups, 1000);
        chk(wrap_dn, "R6 wrap down", int'(wrap_dn), 1);

        // mid-run reset
        pulse_reset();
        @(negedge clk);
        chk(angle == 0 && velocity == 0 && err_mag == 0, "R1 mid-run reset",
            int'(angle) + int'(velocity) + int'(err_mag), 0);

        // saturation under a lowered limit
        vel_limit = 16'd12000;
        hit_lim = 0;
        gk = 0;
        th = 2500.0;
        track(5000, 0.0);
        @(negedge clk);
        chk(hit_lim, "R7 velocity reached limit", int'(hit_lim), 1);
        chk(wdiff(int'(angle), th_mod()) <= TOL && wdiff(int'(angle), th_mod()) >= -TOL,
            "R7 lock after saturation", int'(angle), th_mod());

        chk(multi_jumps == 0, "R2 single-count steps", multi_jumps, 0);
        chk(over_lim == 0, "R7 velocity within limit", over_lim, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule